// File: doc/BRIEF.md
# Configurable Clock Divider Cell

This cell derives one output clock from a set of candidate clocks. A one-bit source switch chooses between a dedicated primary clock and a secondary multiplexer that picks one of several alternate clocks. The chosen clock then passes through one of three paths:

- a straight pass-through,
- a programmable divider whose ratio comes from a 3-bit code,
- a fixed divide-by-three that overrides both other paths.

The last stage is an enable gate that holds the output low while it is disabled.

All control fields are quasi-static configuration inputs. The cell tolerates changes to them at any time. A new ratio is adopted only when the current output period ends. The gate enable is captured on the falling edge of the divided clock. As a result, neither a ratio change nor a gate change can produce a truncated output pulse.

Two parameters make the secondary multiplexer and the gate optional for each instance. Without the multiplexer, only the primary clock is used. Without the gate, the output always runs.

Top module: `clkdiv_cell`

## Requirements
- R1: With `src_alt` = 0 the divider is fed from `clk_primary`, and `alt_sel` has no effect on the output.
- R2: With `src_alt` = 1 the divider is fed from `clk_alt[alt_sel]`. An `alt_sel` value of `NUM_ALT` or above selects `clk_alt[0]`.
- R3: With `div_on` = 1 and `div3_on` = 0, the output period is R input periods. `div_code` values 0..7 give R = 1, 2, 4, 6, 8, 12, 1, 1. For even R the output is high for R/2 input periods.
- R4: With `div3_on` = 1 the output period is 3 input periods, with a high time of 1 period and a low time of 2. This holds whatever `div_on` and `div_code` hold.
- R5: With `div_on` = 0 and `div3_on` = 0 the output repeats the selected clock, with the same period and high time, whatever `div_code` holds.
- R6: With `gate_on` = 0 the output stays low. With `gate_on` = 1 the divided clock is passed.
- R7: A ratio change completes the output period in progress at the old ratio. The first full period that follows uses the new ratio.
- R8: `gate_on` is sampled on the falling edge of the divided clock. After enabling, the first output pulse has full width. After disabling mid-pulse, the pulse in progress completes.
- R9: While `rst_n` is low the output is low. This takes effect asynchronously, without waiting for a clock edge.
- R10: With `HAS_ALT_MUX` = 0 only `clk_primary` is used. With `HAS_GATE` = 0 the output runs regardless of `gate_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_primary | input | 1 | Dedicated primary clock |
| clk_alt | input | NUM_ALT | Alternate candidate clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_alt | input | 1 | 0: primary clock, 1: alternate multiplexer |
| alt_sel | input | ALT_SEL_W | Alternate clock index |
| div_on | input | 1 | 1: programmable divider active, 0: ratio 1 |
| div_code | input | 3 | Ratio code |
| div3_on | input | 1 | Fixed divide-by-three, dominant |
| gate_on | input | 1 | Output enable |
| clk_out | output | 1 | Divided, gated clock |

## Verification
On every edge of the selected clock, the in-line assertions check the following:

- the phase counter stays below the active ratio;
- the latched ratio holds until the final cycle of a period;
- the divide-by-three waveform has exactly one high cycle in three;
- even ratios fall at their midpoint.

Some properties are only visible in absolute time, so only the bench scenarios can show them. These are the period and high time for every source, code and switch combination. They also include the full-width pulses around gate changes, the asynchronous reset response, and the variants with the multiplexer and the gate removed.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    localparam int RATIO_W = 4;
    localparam int CODE_W  = 3;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t cnt;
        ratio_t ratio;
        logic   out;
    } core_state_t;

    function automatic ratio_t code_to_ratio(input logic [CODE_W-1:0] code);
        case (code)
            3'd1:    return ratio_t'(2);
            3'd2:    return ratio_t'(4);
            3'd3:    return ratio_t'(6);
            3'd4:    return ratio_t'(8);
            3'd5:    return ratio_t'(12);
            default: return ratio_t'(1);
        endcase
    endfunction

    function automatic ratio_t high_len(input ratio_t r);
        if (r == ratio_t'(3)) return ratio_t'(1);
        return r >> 1;
    endfunction
endpackage

// File: rtl/clkdiv_src_sel.sv
`timescale 1ns/1ps
module clkdiv_src_sel #(
    parameter int NUM_ALT     = 4,
    parameter int ALT_SEL_W   = 3,
    parameter bit HAS_ALT_MUX = 1'b1
) (
    input  logic                 clk_primary,
    input  logic [NUM_ALT-1:0]   clk_alt,
    input  logic                 src_alt,
    input  logic [ALT_SEL_W-1:0] alt_sel,
    output logic                 clk_src
);
    generate
        if (HAS_ALT_MUX) begin : g_mux
            logic alt_clk;
            always_comb begin
                alt_clk = clk_alt[0];
                for (int i = 1; i < NUM_ALT; i++) begin
                    if (alt_sel == ALT_SEL_W'(i)) alt_clk = clk_alt[i];
                end
            end
            assign clk_src = src_alt ? alt_clk : clk_primary;
        end else begin : g_nomux
            logic unused_sel;
            assign unused_sel = ^{clk_alt, src_alt, alt_sel};
            assign clk_src    = clk_primary;
        end
    endgenerate
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic   clk_src,
    input  logic   rst_n,
    input  ratio_t ratio_in,
    output logic   clk_div
);
    localparam int EXT_W = RATIO_W + 1;

    core_state_t st_d, st_q;
    logic        wrap;

    // Ratio is adopted only on the last cycle of a period (or when idle after reset).
    always_comb begin
        wrap = (EXT_W'(st_q.cnt) + EXT_W'(1)) >= EXT_W'(st_q.ratio);
        st_d = st_q;
        if (wrap) begin
            st_d.cnt   = '0;
            st_d.ratio = ratio_in;
        end else begin
            st_d.cnt   = st_q.cnt + ratio_t'(1);
        end
        st_d.out = st_d.cnt < high_len(st_d.ratio);
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Ratio 1 routes the source straight through; the switch happens at a rising edge.
    assign clk_div = (st_q.ratio == ratio_t'(1)) ? clk_src : st_q.out;

    assert_cnt_in_range_R3: assert property (@(posedge clk_src) disable iff (!rst_n)
        (st_q.ratio != '0) |-> (st_q.cnt < st_q.ratio));

    assert_ratio_hold_R7: assert property (@(posedge clk_src) disable iff (!rst_n)
        (st_q.ratio != '0 && (st_q.cnt + ratio_t'(1)) < st_q.ratio) |=> $stable(st_q.ratio));

    assert_div3_high_R4: assert property (@(posedge clk_src) disable iff (!rst_n)
        (st_q.ratio == ratio_t'(3) && st_q.cnt == '0) |-> st_q.out);

    assert_div3_low_R4: assert property (@(posedge clk_src) disable iff (!rst_n)
        (st_q.ratio == ratio_t'(3) && st_q.cnt != '0) |-> !st_q.out);

    assert_even_mid_low_R3: assert property (@(posedge clk_src) disable iff (!rst_n)
        (st_q.ratio >= ratio_t'(2) && st_q.ratio != ratio_t'(3) && st_q.cnt == (st_q.ratio >> 1))
        |-> !st_q.out);
endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate #(
    parameter bit HAS_GATE = 1'b1
) (
    input  logic clk_div,
    input  logic rst_n,
    input  logic gate_on,
    output logic clk_out
);
    generate
        if (HAS_GATE) begin : g_gate
            logic en_d, en_q;
            always_comb en_d = gate_on;
            // Captured while the divided clock is low so a pulse is never cut.
            always_ff @(negedge clk_div or negedge rst_n) begin
                if (!rst_n) en_q <= 1'b0;
                else        en_q <= en_d;
            end
            assign clk_out = clk_div & en_q;
        end else begin : g_nogate
            logic unused_gate;
            assign unused_gate = gate_on ^ rst_n;
            assign clk_out     = clk_div;
        end
    endgenerate
endmodule

// File: rtl/clkdiv_cell.sv
`timescale 1ns/1ps
module clkdiv_cell
    import clkdiv_pkg::*;
#(
    parameter int NUM_ALT     = 4,
    parameter int ALT_SEL_W   = 3,
    parameter bit HAS_ALT_MUX = 1'b1,
    parameter bit HAS_GATE    = 1'b1
) (
    input  logic                 clk_primary,
    input  logic [NUM_ALT-1:0]   clk_alt,
    input  logic                 rst_n,
    input  logic                 src_alt,
    input  logic [ALT_SEL_W-1:0] alt_sel,
    input  logic                 div_on,
    input  logic [CODE_W-1:0]    div_code,
    input  logic                 div3_on,
    input  logic                 gate_on,
    output logic                 clk_out
);
    logic   clk_src;
    logic   clk_div;
    ratio_t ratio_sel;

    // Divide-by-three dominates, then the divider switch.
    always_comb begin
        if (div3_on)     ratio_sel = ratio_t'(3);
        else if (div_on) ratio_sel = code_to_ratio(div_code);
        else             ratio_sel = ratio_t'(1);
    end

    clkdiv_src_sel #(
        .NUM_ALT(NUM_ALT), .ALT_SEL_W(ALT_SEL_W), .HAS_ALT_MUX(HAS_ALT_MUX)
    ) u_src (
        .clk_primary(clk_primary), .clk_alt(clk_alt), .src_alt(src_alt),
        .alt_sel(alt_sel), .clk_src(clk_src)
    );

    clkdiv_core u_core (
        .clk_src(clk_src), .rst_n(rst_n), .ratio_in(ratio_sel), .clk_div(clk_div)
    );

    clkdiv_gate #(.HAS_GATE(HAS_GATE)) u_gate (
        .clk_div(clk_div), .rst_n(rst_n), .gate_on(gate_on), .clk_out(clk_out)
    );
endmodule

// File: tb/clkdiv_cell_tb.sv
`timescale 1ns/1ps
module clkdiv_cell_tb;
    logic       clk_primary = 1'b0;
    logic       ca0 = 1'b0, ca1 = 1'b0, ca2 = 1'b0, ca3 = 1'b0;
    logic [3:0] clk_alt;
    logic       rst_n = 1'b0;
    logic       src_alt = 1'b0;
    logic [2:0] alt_sel = '0;
    logic       div_on = 1'b0;
    logic [2:0] div_code = '0;
    logic       div3_on = 1'b0;
    logic       gate_on = 1'b1;
    logic       clk_out, clk_out_min;
    int         n_checks = 0;
    int         n_fails  = 0;

    always #2 clk_primary = ~clk_primary;   // 250 MHz
    always #3 ca0 = ~ca0;
    always #5 ca1 = ~ca1;
    always #7 ca2 = ~ca2;
    always #9 ca3 = ~ca3;
    assign clk_alt = {ca3, ca2, ca1, ca0};

    clkdiv_cell u_dut (
        .clk_primary(clk_primary), .clk_alt(clk_alt), .rst_n(rst_n), .src_alt(src_alt),
        .alt_sel(alt_sel), .div_on(div_on), .div_code(div_code), .div3_on(div3_on),
        .gate_on(gate_on), .clk_out(clk_out)
    );

    clkdiv_cell #(.HAS_ALT_MUX(1'b0), .HAS_GATE(1'b0)) u_dut_min (
        .clk_primary(clk_primary), .clk_alt(clk_alt), .rst_n(rst_n), .src_alt(src_alt),
        .alt_sel(alt_sel), .div_on(div_on), .div_code(div_code), .div3_on(div3_on),
        .gate_on(gate_on), .clk_out(clk_out_min)
    );

    function automatic int tb_ratio(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 6;
            4: return 8;
            5: return 12;
            default: return 1;
        endcase
    endfunction

    task automatic check_time(input string req, input string what, input realtime got, input realtime exp);
        realtime d;
        n_checks++;
        d = got - exp;
        if (d < 0) d = -d;
        if (d > 0.01) begin
            n_fails++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, got, exp);
        end
    endtask

    task automatic check_bit(input string req, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic measure(input bit use_min, output realtime per, output realtime hi);
        realtime t1, t2, t3;
        if (!use_min) begin
            @(posedge clk_out); t1 = $realtime;
            @(negedge clk_out); t2 = $realtime;
            @(posedge clk_out); t3 = $realtime;
        end else begin
            @(posedge clk_out_min); t1 = $realtime;
            @(negedge clk_out_min); t2 = $realtime;
            @(posedge clk_out_min); t3 = $realtime;
        end
        per = t3 - t1;
        hi  = t2 - t1;
    endtask

    initial begin
        #600000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        realtime per, hi, t1, t2, t3;
        int highs;

        // R9: output low while reset is held
        for (int k = 0; k < 20; k++) begin
            #1;
            check_bit("R9", "output during reset", clk_out, 1'b0);
        end
        @(negedge clk_primary);
        rst_n = 1'b1;

        // Sweep: source, divide-by-three, divider switch, code (R1..R5)
        for (int src = 0; src < 5; src++) begin
            for (int d3 = 0; d3 < 2; d3++) begin
                for (int de = 0; de < 2; de++) begin
                    for (int code = 0; code < 8; code++) begin
                        int r;
                        realtime tsrc, ehi;
                        string req;
                        src_alt  = (src != 0);
                        alt_sel  = (src == 0) ? 3'(code) : 3'(src - 1);
                        div3_on  = d3[0];
                        div_on   = de[0];
                        div_code = 3'(code);
                        r    = d3 ? 3 : (de ? tb_ratio(code) : 1);
                        tsrc = (src == 0) ? 4.0 : 6.0 + 4.0 * (src - 1);
                        ehi  = (r == 1) ? tsrc / 2.0 : ((r == 3) ? tsrc : tsrc * (r / 2));
                        req  = d3 ? "R4" : (de ? "R3" : "R5");
                        if (src == 0) req = {req, "/R1"};
                        else          req = {req, "/R2"};
                        #500;
                        measure(1'b0, per, hi);
                        check_time(req, $sformatf("period src%0d d3=%0d de=%0d code=%0d", src, d3, de, code),
                                   per, tsrc * r);
                        check_time(req, $sformatf("high src%0d d3=%0d de=%0d code=%0d", src, d3, de, code),
                                   hi, ehi);
                    end
                end
            end
        end

        // R2: out-of-range alternate index falls back to clk_alt[0]
        src_alt = 1'b1; alt_sel = 3'd6; div3_on = 1'b0; div_on = 1'b0;
        #500; measure(1'b0, per, hi);
        check_time("R2", "out-of-range index period", per, 6.0);
        alt_sel = 3'd5; div_on = 1'b1; div_code = 3'd1;
        #500; measure(1'b0, per, hi);
        check_time("R2", "out-of-range index ratio 2 period", per, 12.0);

        // R10: variant without mux ignores src_alt
        src_alt = 1'b1; alt_sel = 3'd3; div_code = 3'd2;
        #500; measure(1'b1, per, hi);
        check_time("R10", "no-mux variant period", per, 16.0);

        // R6: gate off holds output low; R10: gateless variant keeps running
        src_alt = 1'b0; gate_on = 1'b0;
        #300;
        highs = 0;
        for (int k = 0; k < 300; k++) begin
            #1;
            if (clk_out) highs++;
        end
        n_checks++;
        if (highs != 0) begin
            n_fails++;
            $display("FAIL R6 gated output high samples: actual %0d expected 0", highs);
        end
        measure(1'b1, per, hi);
        check_time("R10", "gateless variant period with gate off", per, 16.0);
        check_time("R10", "gateless variant high with gate off", hi, 8.0);

        // R8: enabling at arbitrary phases gives a full first pulse
        #7; gate_on = 1'b1;
        @(posedge clk_out); t1 = $realtime;
        @(negedge clk_out); t2 = $realtime;
        check_time("R8", "first pulse after enable (offset A)", t2 - t1, 8.0);
        gate_on = 1'b0; #100;
        #11; gate_on = 1'b1;
        @(posedge clk_out); t1 = $realtime;
        @(negedge clk_out); t2 = $realtime;
        check_time("R8", "first pulse after enable (offset B)", t2 - t1, 8.0);
        check_time("R6", "enabled pulse width", t2 - t1, 8.0);

        // R8: disabling mid-pulse lets the pulse finish
        @(posedge clk_out); #2; gate_on = 1'b0;
        #3;
        check_bit("R8", "pulse continues after disable", clk_out, 1'b1);
        #40;
        check_bit("R6", "output low after disable", clk_out, 1'b0);
        gate_on = 1'b1;

        // R7: ratio change mid-period completes the old period
        div_code = 3'd5;
        #500;
        @(posedge clk_out); t1 = $realtime;
        #10; div_code = 3'd1;
        @(negedge clk_out); t2 = $realtime;
        @(posedge clk_out); t3 = $realtime;
        check_time("R7", "old high time kept", t2 - t1, 24.0);
        check_time("R7", "old period kept", t3 - t1, 48.0);
        measure(1'b0, per, hi);
        check_time("R7", "new period", per, 8.0);

        // R9: asynchronous reset mid-run drives output low at once
        div_on = 1'b0;
        #200;
        @(posedge clk_primary); #0.5;
        rst_n = 1'b0;
        #0.5;
        check_bit("R9", "output low right after async reset", clk_out, 1'b0);
        #20;
        check_bit("R9", "output stays low in reset", clk_out, 1'b0);
        @(negedge clk_primary); rst_n = 1'b1;
        #500; measure(1'b0, per, hi);
        check_time("R9", "period after reset release", per, 4.0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule